// File: doc/BRIEF.md
# Legacy Backplane Core Reset Sequencer

This block walks one core on an older shared-bus backplane through a quiesce-and-hold disable, and optionally through a full re-initialisation after it. It is a small 32-bit register master. It reaches four registers of the target core's agent: a low control/state word, a high status word, an initiator-state word and an identification word. Each single access completes on a one-cycle acknowledge. Software, or another controller, gives it one of three command pulses. A free-running microsecond tick times its settle waits and bounds its busy polls.

A disable first asks the target port to reject new traffic. It waits for in-flight work to drain. When the identification word marks the core as a bus initiator, it does the same on the initiator side. It then forces the clocks with reset held, and finally parks the core in reset with reject set. A reset command runs that disable and then brings the core back up. It clears latched error bits on the way, then releases forced clocking and reset in separate timed steps. A status query reads the low word and reports whether the core is running. Each command ends with a single-cycle `done`. A drain poll that exceeds its limit raises `timeout_error`, and the sequence carries on.

Top module: `bkp_core_reset_seq`

## Requirements
- R1: A query reads the low word (select 0) and performs no write. `core_up` becomes 1 exactly when, of the bits reset (bit 0), reject (bit 1), initiator-reject mirror (bit 3) and clock (bit 16), only clock is set. Other bits, such as force-clock (bit 17), are ignored. `core_up` is 0 after reset and changes only in the cycle `done` pulses for a query.
- R2: If the low word reads with reset (bit 0) set, the disable part performs no write at all.
- R3: If reset is clear and clock (bit 16) is clear, the disable part writes only reject|reset (0x0000_0003) to the low word.
- R4: If clock is set, the first write puts reject into the low word and keeps every other bit read. After 1 µs, the high word (select 1) is polled until target-busy (bit 2) reads clear.
- R5: When identification (select 3) bit 7 is set, the initiator word (select 2) gets initiator-reject (bit 25) by read-modify-write, and initiator-busy (bit 24) is polled. After the forced-clock write, bit 25 is cleared again by read-modify-write. When bit 7 is clear, the initiator word is never written during disable.
- R6: With clock set, the low word is then written with force-clock|clock|reject|reset (0x0003_0003). No later write follows until at least 10 ticks have passed. The disable part ends with reject|reset (0x0000_0003).
- R7: A drain poll still busy after the poll limit (in ticks) sets `timeout_error`. The sequence continues with its remaining writes. `timeout_error` holds until the next accepted command clears it.
- R8: After the disable part, a reset command writes force-clock|clock|reset (0x0003_0001). It writes 0 to the high word only if its error bit (bit 0) is set. It clears inbound-error (bit 17) and timeout (bit 18) in the initiator word by read-modify-write, only if either is set. It then writes 0x0003_0000 and finally 0x0001_0000 to the low word.
- R9: Every write is followed at once by a read of the same register before any other access.
- R10: `done` pulses for exactly one cycle per accepted command, with no access outstanding. Commands arriving while a sequence runs are ignored. Simultaneous pulses are ranked reset over disable over query.
- R11: A request holds its select, direction and data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_disable | input | 1 | Pulse: start a disable |
| cmd_reset | input | 1 | Pulse: start disable followed by re-initialisation |
| cmd_query | input | 1 | Pulse: sample the core-running status |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| req_valid | output | 1 | Register access request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_sel | output | 2 | Register select: 0 low, 1 high, 2 initiator, 3 identification |
| req_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completed (one cycle) |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| done | output | 1 | One-cycle completion pulse |
| core_up | output | 1 | Last queried running status |
| timeout_error | output | 1 | A drain poll exceeded its limit |

## Verification
The case where two functions meet is a new command pulse landing while a sequence is already running. The acceptance logic and the sequence stepping then both act on the same cycle. The bench provokes this by pulsing `cmd_reset` a few cycles into a disable. It judges the result with the write scoreboard: any re-initialisation write would show up as an unexpected item, and a second `done` would break the one-pulse count. A second meeting point is a drain poll whose limit expires on the same read that still shows busy. There the bench checks that the flag is raised and that the following writes still arrive in order.

// File: rtl/bkrst_pkg.sv
package bkrst_pkg;

  localparam int unsigned REG_W = 32;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_LO = 2'd0,
    SEL_HI = 2'd1,
    SEL_IM = 2'd2,
    SEL_ID = 2'd3
  } reg_sel_e;

  // low control/state word
  localparam int unsigned LO_RST_B = 0;
  localparam int unsigned LO_REJ_B = 1;
  localparam int unsigned LO_IRJ_B = 3;
  localparam int unsigned LO_CLK_B = 16;
  localparam int unsigned LO_FGC_B = 17;
  // high status word
  localparam int unsigned HI_ERR_B  = 0;
  localparam int unsigned HI_BUSY_B = 2;
  // initiator-state word
  localparam int unsigned IM_IBE_B  = 17;
  localparam int unsigned IM_TO_B   = 18;
  localparam int unsigned IM_BUSY_B = 24;
  localparam int unsigned IM_REJ_B  = 25;
  // identification word
  localparam int unsigned ID_INIT_B = 7;

  localparam logic [REG_W-1:0] LO_RST_M = REG_W'(1) << LO_RST_B;
  localparam logic [REG_W-1:0] LO_REJ_M = REG_W'(1) << LO_REJ_B;
  localparam logic [REG_W-1:0] LO_IRJ_M = REG_W'(1) << LO_IRJ_B;
  localparam logic [REG_W-1:0] LO_CLK_M = REG_W'(1) << LO_CLK_B;
  localparam logic [REG_W-1:0] LO_FGC_M = REG_W'(1) << LO_FGC_B;
  localparam logic [REG_W-1:0] IM_REJ_M = REG_W'(1) << IM_REJ_B;
  localparam logic [REG_W-1:0] IM_CLR_M = (REG_W'(1) << IM_IBE_B) | (REG_W'(1) << IM_TO_B);
  localparam logic [REG_W-1:0] UP_MASK  = LO_RST_M | LO_REJ_M | LO_IRJ_M | LO_CLK_M;

  typedef enum logic [4:0] {
    ST_IDLE, ST_RD, ST_WR, ST_RB, ST_DLY, ST_Q,
    ST_D_CHK, ST_D_TPSTART, ST_D_TPOLL, ST_D_IDRD, ST_D_ID,
    ST_D_IREJ, ST_D_IPSTART, ST_D_IPOLL, ST_D_FORCE,
    ST_D_ICLRRD, ST_D_ICLR, ST_D_LAST,
    ST_R_INIT, ST_R_HIRD, ST_R_HI, ST_R_IMRD, ST_R_IM,
    ST_R_REL, ST_R_CLK, ST_FIN
  } seq_st_e;

endpackage

// File: rtl/bkrst_access_port.sv
module bkrst_access_port #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [SW-1:0] sel,
  input  logic [DW-1:0] wdata,
  output logic          op_done,
  output logic [DW-1:0] rdata,
  output logic          req_valid,
  output logic          req_write,
  output logic [SW-1:0] req_sel,
  output logic [DW-1:0] req_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_sel   <= '0;
      req_wdata <= '0;
      op_done   <= 1'b0;
      rdata     <= '0;
    end else begin
      op_done <= 1'b0;
      if (req_valid && bus_ack) begin
        req_valid <= 1'b0;
        op_done   <= 1'b1;
        if (!req_write) rdata <= bus_rdata;
      end else if (start && !req_valid) begin
        req_valid <= 1'b1;
        req_write <= wr;
        req_sel   <= sel;
        req_wdata <= wdata;
      end
    end
  end

endmodule

// File: rtl/bkrst_us_counter.sv
module bkrst_us_counter #(
  parameter int unsigned CW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick && cnt != TOP) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/bkrst_sequencer.sv
module bkrst_sequencer
  import bkrst_pkg::*;
#(
  parameter int unsigned CW            = 18,
  parameter int unsigned POLL_LIMIT_US = 100000,
  parameter int unsigned SETTLE_US     = 1,
  parameter int unsigned FORCE_HOLD_US = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_disable,
  input  logic             cmd_reset,
  input  logic             cmd_query,
  input  logic [CW-1:0]    cnt,
  output logic             cnt_clr,
  output logic             port_start,
  output logic             port_wr,
  output reg_sel_e         port_sel,
  output logic [REG_W-1:0] port_wdata,
  input  logic             port_done,
  input  logic [REG_W-1:0] port_rdata,
  output logic             done,
  output logic             core_up,
  output logic             timeout_error
);

  localparam logic [CW-1:0] LIM    = CW'(POLL_LIMIT_US);
  localparam logic [CW-1:0] SETTLE = CW'(SETTLE_US);
  localparam logic [CW-1:0] HOLD   = CW'(FORCE_HOLD_US);

  seq_st_e       st, ret;
  logic [CW-1:0] dly;
  logic          do_reset;
  logic          is_init;

  assign cnt_clr = (st == ST_RB && port_done) || st == ST_D_TPSTART || st == ST_D_IPSTART;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      ret           <= ST_IDLE;
      dly           <= '0;
      do_reset      <= 1'b0;
      is_init       <= 1'b0;
      port_start    <= 1'b0;
      port_wr       <= 1'b0;
      port_sel      <= SEL_LO;
      port_wdata    <= '0;
      done          <= 1'b0;
      core_up       <= 1'b0;
      timeout_error <= 1'b0;
    end else begin
      port_start <= 1'b0;
      done       <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_reset || cmd_disable) begin
            do_reset      <= cmd_reset;
            timeout_error <= 1'b0;
            port_start <= 1'b1; port_wr <= 1'b0; port_sel <= SEL_LO;
            ret <= ST_D_CHK; st <= ST_RD;
          end else if (cmd_query) begin
            timeout_error <= 1'b0;
            port_start <= 1'b1; port_wr <= 1'b0; port_sel <= SEL_LO;
            ret <= ST_Q; st <= ST_RD;
          end
        end
        // generic single read
        ST_RD: if (port_done) st <= ret;
        // generic write, then readback of the same register
        ST_WR: if (port_done) begin
          port_start <= 1'b1; port_wr <= 1'b0;
          st <= ST_RB;
        end
        ST_RB: if (port_done) st <= (dly == '0) ? ret : ST_DLY;
        ST_DLY: if (cnt >= dly) st <= ret;
        ST_Q: begin
          core_up <= (port_rdata & UP_MASK) == LO_CLK_M;
          done    <= 1'b1;
          st      <= ST_IDLE;
        end
        // ---------------- disable part ----------------
        ST_D_CHK: begin
          if (port_rdata[LO_RST_B]) begin
            st <= do_reset ? ST_R_INIT : ST_FIN;
          end else if (!port_rdata[LO_CLK_B]) begin
            st <= ST_D_LAST;
          end else begin
            port_start <= 1'b1; port_wr <= 1'b1; port_sel <= SEL_LO;
            port_wdata <= port_rdata | LO_REJ_M;
            dly <= SETTLE; ret <= ST_D_TPSTART; st <= ST_WR;
          end
        end
        ST_D_TPSTART: begin
          port_start <= 1'b1; port_wr <= 1'b0; port_sel <= SEL_HI;
          ret <= ST_D_TPOLL; st <= ST_RD;
        end
        ST_D_TPOLL: begin
          if (!port_rdata[HI_BUSY_B]) begin
            st <= ST_D_IDRD;
          end else if (cnt >= LIM) begin
            timeout_error <= 1'b1;
            st <= ST_D_IDRD;
          end else begin
            port_start <= 1'b1; port_wr <= 1'b0; port_sel <= SEL_HI;
            ret <= ST_D_TPOLL; st <= ST_RD;
          end
        end
        ST_D_IDRD: begin
          port_start <= 1'b1; port_wr <= 1'b0; port_sel <= SEL_ID;
          ret <= ST_D_ID; st <= ST_RD;
        end
        ST_D_ID: begin
          is_init <= port_rdata[ID_INIT_B];
          if (port_rdata[ID_INIT_B]) begin
            port_start <= 1'b1; port_wr <= 1'b0; port_sel <= SEL_IM;
            ret <= ST_D_IREJ; st <= ST_RD;
          end else begin
            st <= ST_D_FORCE;
          end
        end
        ST_D_IREJ: begin
          port_start <= 1'b1; port_wr <= 1'b1; port_sel <= SEL_IM;
          port_wdata <= port_rdata | IM_REJ_M;
          dly <= SETTLE; ret <= ST_D_IPSTART; st <= ST_WR;
        end
        ST_D_IPSTART: begin
          port_start <= 1'b1; port_wr <= 1'b0; port_sel <= SEL_IM;
          ret <= ST_D_IPOLL; st <= ST_RD;
        end
        ST_D_IPOLL: begin
          if (!port_rdata[IM_BUSY_B]) begin
            st <= ST_D_FORCE;
          end else if (cnt >= LIM) begin
            timeout_error <= 1'b1;
            st <= ST_D_FORCE;
          end else begin
            port_start <= 1'b1; port_wr <= 1'b0; port_sel <= SEL_IM;
            ret <= ST_D_IPOLL; st <= ST_RD;
          end
        end
        ST_D_FORCE: begin
          port_start <= 1'b1; port_wr <= 1'b1; port_sel <= SEL_LO;
          port_wdata <= LO_FGC_M | LO_CLK_M | LO_REJ_M | LO_RST_M;
          dly <= HOLD; ret <= is_init ? ST_D_ICLRRD : ST_D_LAST; st <= ST_WR;
        end
        ST_D_ICLRRD: begin
          port_start <= 1'b1; port_wr <= 1'b0; port_sel <= SEL_IM;
          ret <= ST_D_ICLR; st <= ST_RD;
        end
        ST_D_ICLR: begin
          port_start <= 1'b1; port_wr <= 1'b1; port_sel <= SEL_IM;
          port_wdata <= port_rdata & ~IM_REJ_M;
          dly <= '0; ret <= ST_D_LAST; st <= ST_WR;
        end
        ST_D_LAST: begin
          port_start <= 1'b1; port_wr <= 1'b1; port_sel <= SEL_LO;
          port_wdata <= LO_REJ_M | LO_RST_M;
          dly <= SETTLE; ret <= do_reset ? ST_R_INIT : ST_FIN; st <= ST_WR;
        end
        // ---------------- re-initialisation part ----------------
        ST_R_INIT: begin
          port_start <= 1'b1; port_wr <= 1'b1; port_sel <= SEL_LO;
          port_wdata <= LO_FGC_M | LO_CLK_M | LO_RST_M;
          dly <= SETTLE; ret <= ST_R_HIRD; st <= ST_WR;
        end
        ST_R_HIRD: begin
          port_start <= 1'b1; port_wr <= 1'b0; port_sel <= SEL_HI;
          ret <= ST_R_HI; st <= ST_RD;
        end
        ST_R_HI: begin
          if (port_rdata[HI_ERR_B]) begin
            port_start <= 1'b1; port_wr <= 1'b1; port_sel <= SEL_HI;
            port_wdata <= '0;
            dly <= '0; ret <= ST_R_IMRD; st <= ST_WR;
          end else begin
            st <= ST_R_IMRD;
          end
        end
        ST_R_IMRD: begin
          port_start <= 1'b1; port_wr <= 1'b0; port_sel <= SEL_IM;
          ret <= ST_R_IM; st <= ST_RD;
        end
        ST_R_IM: begin
          if ((port_rdata & IM_CLR_M) != '0) begin
            port_start <= 1'b1; port_wr <= 1'b1; port_sel <= SEL_IM;
            port_wdata <= port_rdata & ~IM_CLR_M;
            dly <= '0; ret <= ST_R_REL; st <= ST_WR;
          end else begin
            st <= ST_R_REL;
          end
        end
        ST_R_REL: begin
          port_start <= 1'b1; port_wr <= 1'b1; port_sel <= SEL_LO;
          port_wdata <= LO_FGC_M | LO_CLK_M;
          dly <= SETTLE; ret <= ST_R_CLK; st <= ST_WR;
        end
        ST_R_CLK: begin
          port_start <= 1'b1; port_wr <= 1'b1; port_sel <= SEL_LO;
          port_wdata <= LO_CLK_M;
          dly <= SETTLE; ret <= ST_FIN; st <= ST_WR;
        end
        ST_FIN: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bkp_core_reset_seq.sv
module bkp_core_reset_seq
  import bkrst_pkg::*;
#(
  parameter int unsigned POLL_LIMIT_US = 100000,
  parameter int unsigned SETTLE_US     = 1,
  parameter int unsigned FORCE_HOLD_US = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_disable,
  input  logic        cmd_reset,
  input  logic        cmd_query,
  input  logic        us_tick,
  output logic        req_valid,
  output logic        req_write,
  output logic [1:0]  req_sel,
  output logic [31:0] req_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata,
  output logic        done,
  output logic        core_up,
  output logic        timeout_error
);

  localparam int unsigned MAX_A = (POLL_LIMIT_US > FORCE_HOLD_US) ? POLL_LIMIT_US : FORCE_HOLD_US;
  localparam int unsigned MAX_W = (MAX_A > SETTLE_US) ? MAX_A : SETTLE_US;
  localparam int unsigned CW    = $clog2(MAX_W + 1) + 1;

  logic             cnt_clr;
  logic [CW-1:0]    cnt;
  logic             port_start;
  logic             port_wr;
  reg_sel_e         port_sel;
  logic [REG_W-1:0] port_wdata;
  logic             port_done;
  logic [REG_W-1:0] port_rdata;

  bkrst_us_counter #(.CW(CW)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .tick (us_tick),
    .cnt  (cnt)
  );

  bkrst_access_port #(.DW(REG_W), .SW(SEL_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .start     (port_start),
    .wr        (port_wr),
    .sel       (port_sel),
    .wdata     (port_wdata),
    .op_done   (port_done),
    .rdata     (port_rdata),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sel   (req_sel),
    .req_wdata (req_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata)
  );

  bkrst_sequencer #(
    .CW            (CW),
    .POLL_LIMIT_US (POLL_LIMIT_US),
    .SETTLE_US     (SETTLE_US),
    .FORCE_HOLD_US (FORCE_HOLD_US)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .cmd_disable   (cmd_disable),
    .cmd_reset     (cmd_reset),
    .cmd_query     (cmd_query),
    .cnt           (cnt),
    .cnt_clr       (cnt_clr),
    .port_start    (port_start),
    .port_wr       (port_wr),
    .port_sel      (port_sel),
    .port_wdata    (port_wdata),
    .port_done     (port_done),
    .port_rdata    (port_rdata),
    .done          (done),
    .core_up       (core_up),
    .timeout_error (timeout_error)
  );

endmodule

// File: rtl/bkrst_chk.sv
module bkrst_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_sel,
  input logic [31:0] req_wdata,
  input logic        bus_ack,
  input logic        done,
  input logic        core_up
);

  logic       wr_pend;
  logic [1:0] wr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend <= 1'b0;
      wr_sel  <= '0;
    end else if (req_valid && bus_ack) begin
      wr_pend <= req_write;
      wr_sel  <= req_sel;
    end
  end

  // R9
  readback_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_valid) && wr_pend) |-> (!req_write && req_sel == wr_sel));

  // R11
  request_held_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !bus_ack) |=> (req_valid && $stable(req_sel) && $stable(req_write) && $stable(req_wdata)));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);

  // R1
  status_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(core_up) |-> done);

endmodule

bind bkp_core_reset_seq bkrst_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_sel   (req_sel),
  .req_wdata (req_wdata),
  .bus_ack   (bus_ack),
  .done      (done),
  .core_up   (core_up)
);

// File: tb/bkp_core_reset_seq_test.sv
module bkp_core_reset_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 40;
  localparam int HOLD       = 10;

  localparam logic [31:0] RST_V = 32'h0000_0001;
  localparam logic [31:0] REJ_V = 32'h0000_0002;
  localparam logic [31:0] IRJ_V = 32'h0000_0008;
  localparam logic [31:0] CLK_V = 32'h0001_0000;
  localparam logic [31:0] FGC_V = 32'h0002_0000;
  localparam logic [31:0] TBSY  = 32'h0000_0004;
  localparam logic [31:0] SERR  = 32'h0000_0001;
  localparam logic [31:0] IBE   = 32'h0002_0000;
  localparam logic [31:0] ITO   = 32'h0004_0000;
  localparam logic [31:0] IBSY  = 32'h0100_0000;
  localparam logic [31:0] IREJ  = 32'h0200_0000;
  localparam logic [31:0] INIT  = 32'h0000_0080;

  typedef struct {
    logic [1:0]  sel;
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_disable = 1'b0, cmd_reset = 1'b0, cmd_query = 1'b0;
  logic us_tick = 1'b0;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic req_valid, req_write, done, core_up, timeout_error;
  logic [1:0]  req_sel;
  logic [31:0] req_wdata;

  int n_chk = 0, n_bad = 0, done_cnt = 0, tick_total = 0, div = 0;
  exp_t expq[$];
  logic [31:0] m_lo, m_hi, m_im, m_id;
  int tbusy_left, ibusy_left;
  bit last_wr = 0; logic [1:0] last_sel = '0;
  bit force_pend = 0; int force_t = 0;

  bkp_core_reset_seq #(.POLL_LIMIT_US(LIMIT), .SETTLE_US(1), .FORCE_HOLD_US(HOLD)) uut (
    .clk(clk), .rst(rst), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
    .cmd_query(cmd_query), .us_tick(us_tick), .req_valid(req_valid),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .core_up(core_up),
    .timeout_error(timeout_error));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // tick generator: one tick every third cycle
  always @(negedge clk) begin
    div = (div + 1) % 3;
    us_tick = (div == 0);
    if (us_tick) tick_total++;
  end

  // register model + scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0;
      last_wr = 0;
    end else if (req_valid && !bus_ack) begin
      if (last_wr)
        chk(!req_write && req_sel == last_sel, "R9 readback after write", {30'd0, req_sel}, {30'd0, last_sel});
      last_wr  = req_write;
      last_sel = req_sel;
      if (req_write) begin
        if (force_pend) begin
          chk(tick_total - force_t >= HOLD, "R6 hold after forced clock", tick_total - force_t, HOLD);
          force_pend = 0;
        end
        if (req_sel == 2'd0 && req_wdata == (FGC_V | CLK_V | REJ_V | RST_V)) begin
          force_pend = 1;
          force_t = tick_total;
        end
        if (expq.size() == 0) begin
          chk(0, "R10 unexpected write", {30'd0, req_sel}, 32'hFFFF_FFFF);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(req_sel == e.sel && req_wdata == e.data, e.tag, req_wdata, e.data);
        end
        case (req_sel)
          2'd0: m_lo = req_wdata;
          2'd1: m_hi = req_wdata & ~TBSY;
          2'd2: m_im = req_wdata & ~IBSY;
          default: m_id = req_wdata;
        endcase
      end else begin
        case (req_sel)
          2'd0: bus_rdata = m_lo;
          2'd1: begin
            bus_rdata = m_hi;
            if (m_lo[1] && tbusy_left > 0) begin bus_rdata |= TBSY; tbusy_left--; end
          end
          2'd2: begin
            bus_rdata = m_im;
            if (m_im[25] && ibusy_left > 0) begin bus_rdata |= IBSY; ibusy_left--; end
          end
          default: bus_rdata = m_id;
        endcase
      end
      bus_ack = 1'b1;
    end else begin
      bus_ack = 1'b0;
    end
    if (done) done_cnt++;
  end

  task automatic push(input logic [1:0] s, input logic [31:0] d, input string tag);
    exp_t e;
    e.sel = s; e.data = d; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic fire(input int kind);
    if (kind == 0) cmd_query = 1'b1;
    else if (kind == 1) cmd_disable = 1'b1;
    else cmd_reset = 1'b1;
    @(negedge clk);
    cmd_query = 1'b0; cmd_disable = 1'b0; cmd_reset = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    for (int i = 0; i < 20000 && done_cnt == d0; i++) @(negedge clk);
    if (done_cnt == d0) begin
      chk(0, "R10 watchdog no done", 0, 1);
      summary();
    end
  endtask

  // driver: sets the model, predicts the write stream, runs the command
  task automatic run_seq(input int kind, input logic [31:0] lo0, input logic [31:0] hi0,
                         input logic [31:0] im0, input bit init, input int tb, input int ib,
                         input bit exp_tmo, input bit exp_up, input bit interrupt);
    int d0;
    m_lo = lo0; m_hi = hi0; m_im = im0; m_id = init ? (INIT | 32'h4000_0000) : 32'h4000_0000;
    tbusy_left = tb; ibusy_left = ib; force_pend = 0;
    if (kind != 0) begin
      if (lo0[0]) begin
        // R2: nothing written by the disable part
      end else if (!lo0[16]) begin
        push(2'd0, REJ_V | RST_V, "R3 park without clock");
      end else begin
        push(2'd0, lo0 | REJ_V, "R4 target reject keeps bits");
        if (init) push(2'd2, im0 | IREJ, "R5 initiator reject");
        push(2'd0, FGC_V | CLK_V | REJ_V | RST_V, "R6 forced clock in reset");
        if (init) push(2'd2, im0, "R5 initiator reject cleared");
        push(2'd0, REJ_V | RST_V, "R6 final park");
      end
      if (kind == 2) begin
        push(2'd0, FGC_V | CLK_V | RST_V, "R8 clocks on in reset");
        if (hi0[0]) push(2'd1, 32'd0, "R8 error clear");
        if ((im0 & (IBE | ITO)) != 0) push(2'd2, im0 & ~(IBE | ITO), "R8 initiator error clear");
        push(2'd0, FGC_V | CLK_V, "R8 reset released");
        push(2'd0, CLK_V, "R8 clock only");
      end
    end
    d0 = done_cnt;
    fire(kind);
    if (interrupt) begin
      repeat (6) @(negedge clk);
      fire(2);
    end
    wait_done(d0);
    repeat (40) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10 one done per command", done_cnt - d0, 1);
    chk(expq.size() == 0, "R2 R3 R8 all predicted writes seen", expq.size(), 0);
    expq.delete();
    chk(timeout_error == exp_tmo, "R7 timeout flag", {31'd0, timeout_error}, {31'd0, exp_tmo});
    if (kind == 0) chk(core_up == exp_up, "R1 running status", {31'd0, core_up}, {31'd0, exp_up});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R10 global watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0, "R10 reset done low", {31'd0, done}, 0);
    chk(core_up == 0, "R1 reset status low", {31'd0, core_up}, 0);
    chk(timeout_error == 0, "R7 reset flag low", {31'd0, timeout_error}, 0);
    chk(req_valid == 0, "R11 reset no request", {31'd0, req_valid}, 0);

    // R1: query under several low-word patterns
    run_seq(0, CLK_V,               0, 0, 0, 0, 0, 0, 1, 0);
    run_seq(0, CLK_V | REJ_V,       0, 0, 0, 0, 0, 0, 0, 0);
    run_seq(0, CLK_V | IRJ_V,       0, 0, 0, 0, 0, 0, 0, 0);
    run_seq(0, CLK_V | FGC_V | 32'h10, 0, 0, 0, 0, 0, 0, 1, 0);
    run_seq(0, RST_V | CLK_V,       0, 0, 0, 0, 0, 0, 0, 0);
    run_seq(0, 32'd0,               0, 0, 0, 0, 0, 0, 0, 0);
    // R2: already in reset
    run_seq(1, RST_V | REJ_V, 0, 0, 1, 0, 0, 0, 0, 0);
    // R3: clock off
    run_seq(1, 32'h0000_0100, 0, 0, 1, 0, 0, 0, 0, 0);
    // R4 R6: clock on, target only
    run_seq(1, CLK_V | 32'h0000_0040, 0, 0, 0, 2, 0, 0, 0, 0);
    // R5: initiator core
    run_seq(1, CLK_V, 0, 32'h0000_0010, 1, 2, 2, 0, 0, 0);
    // R7: target busy never clears
    run_seq(1, CLK_V, 0, 0, 0, 1000000, 0, 1, 0, 0);
    // R7: next command clears the flag
    run_seq(0, CLK_V, 0, 0, 0, 0, 0, 0, 1, 0);
    // R8: full reset on an initiator with latched errors
    run_seq(2, CLK_V, SERR, IBE | 32'h0000_0008, 1, 1, 2, 0, 0, 0);
    // R8 R2: reset starting from held reset, timeout bit only
    run_seq(2, RST_V | REJ_V, 0, ITO, 0, 0, 0, 0, 0, 0);
    // R10: reset pulse during a running disable is ignored
    run_seq(1, CLK_V, 0, 0, 0, 3, 0, 0, 0, 1);
    // R1: status after the reset sequence
    run_seq(0, CLK_V, 0, 0, 0, 0, 0, 0, 1, 0);
    summary();
  end

endmodule